// File: doc/BRIEF.md
# Instruction Fetch Bus Master

This block is the instruction-side master of a core with separate instruction and data buses. It keeps the address of the next fetch in a register. It sends read-only, word-sized requests on a dedicated valid/ready request channel and takes the replies on an independent valid/ready response channel. Each fetched word is presented downstream with a valid flag, the address it came from, and a fault indication with a 4-bit architectural cause code. A redirect input loads a new fetch address at any time. A stall input holds the presented instruction until the consumer can take it.

Two fault classes are told apart. A fetch address with nonzero low bits is found locally: no bus request is made and the fault is presented at once. A response carrying the error bit becomes an access fault. After either fault the block stops fetching until it is redirected. At most one request is in flight. A redirect that lands while a request is pending or in flight marks that reply for discarding, and fetching restarts from the new address.

Top module: `ifetch_master`

## Requirements
- R1: Every request has write enable 0, size 2'b10 (word), byte strobes 4'b0000, write data zero and atomic-operation field 4'b0000.
- R2: While reqValid is high and reqReady is low, reqValid stays high and reqAddr does not change on the next cycle.
- R3: A fetch address whose bits 1:0 are nonzero is never put on the bus. The block presents instValid with instFault=1, instCause=0 and instPc equal to that address, then issues no request until a redirect.
- R4: A response with rspErr=1 is presented with instFault=1, instCause=1 and instPc equal to the request address. The block then issues no request until a redirect.
- R5: A good response is presented on the cycle after its response handshake, with instWord equal to rspRdata, instFault=0, instCause=0 and instPc equal to the request address. Fresh requests step through addresses by 4.
- R6: No new request is raised in the cycle after a request handshake, and none while a response is outstanding.
- R7: A redirect clears instValid on the next cycle. A response to a request that was raised or in flight at the time of a redirect is never presented. The next fresh request uses the redirect address.
- R8: While instValid is high and stall is high, and no redirect is given, instWord and instPc hold and instValid stays high. A response that is not being discarded is not accepted (rspReady low) until the slot frees.
- R9: During reset reqValid and instValid are 0. The first request after reset uses address RESET_PC.
- R10: Responses that arrive any number of cycles (one or more) after the request handshake are handled correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| redirectValid | input | 1 | Load a new fetch address this cycle |
| redirectPc | input | ADDR_W | New fetch address |
| stall | input | 1 | Downstream cannot take the presented instruction |
| reqValid | output | 1 | Request channel valid |
| reqReady | input | 1 | Request channel ready from the slave |
| reqAddr | output | ADDR_W | Byte address of the word fetched |
| reqWe | output | 1 | Write enable, always 0 |
| reqSize | output | 2 | Access size, always word (2'b10) |
| reqWdata | output | DATA_W | Write data, always zero |
| reqWstrb | output | DATA_W/8 | Byte strobes, always zero |
| reqAmo | output | AMO_W | Atomic operation code, always zero |
| rspValid | input | 1 | Response channel valid |
| rspReady | output | 1 | Response channel ready from this block |
| rspRdata | input | DATA_W | Fetched word |
| rspErr | input | 1 | Slave-reported access fault |
| instValid | output | 1 | Presented instruction is valid |
| instWord | output | DATA_W | Presented instruction word |
| instPc | output | ADDR_W | Address of the presented instruction |
| instFault | output | 1 | Presented entry is a fault |
| instCause | output | 4 | Fault cause: 0 misaligned address, 1 access fault |

## Verification
The hardest case to reach is a redirect that arrives while a request is still held with reqReady low. Its reply then arrives several cycles later, while the presented slot is stalled. The stale reply must be absorbed without showing up, and the fresh request must carry the new address. The stimulus reaches this with random ready, stall and latency settings that become heavier in a late phase. A directed window holds reqReady low and fires a redirect in the middle of it. Directed redirects to a misaligned address, and to a run of addresses that walks into the slave's error region, cover both fault causes and the stop that follows each one.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

  localparam int CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 4'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ACCESS   = 4'd1;
  localparam logic [1:0]         SIZE_WORD      = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_HALT
  } fetchState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic redirect;       // load fetch address from redirectPc, flush slot
    logic incPc;          // advance fetch address past the accepted request
    logic latchAddr;      // capture fetch address as request address
    logic writeInst;      // load slot from the response
    logic writeMisalign;  // load slot with a misaligned-address fault
    logic retire;         // slot may empty this cycle
  } fetchCtl_t;

endpackage

// File: rtl/ifetch_ctrl.sv
module ifetch_ctrl
  import ifetch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      redirectValid,
  input  logic      stall,
  input  logic      misaligned,
  input  logic      outValid,
  input  logic      reqReady,
  input  logic      rspValid,
  input  logic      rspErr,
  output logic      reqValid,
  output logic      rspReady,
  output fetchCtl_t ctl
);

  fetchState_t state, nextState;
  logic        discard, nextDiscard;
  logic        slotFree;
  logic        dropRsp;

  assign slotFree = !outValid || !stall;
  assign dropRsp  = discard || redirectValid;

  always_comb begin
    ctl          = '0;
    ctl.redirect = redirectValid;
    ctl.retire   = !stall;
    nextState    = state;
    nextDiscard  = discard;
    reqValid     = 1'b0;
    rspReady     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (!redirectValid) begin
          if (misaligned) begin
            if (slotFree) begin
              ctl.writeMisalign = 1'b1;
              nextState         = ST_HALT;
            end
          end else begin
            ctl.latchAddr = 1'b1;
            nextState     = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        reqValid = 1'b1;
        if (redirectValid) nextDiscard = 1'b1;
        if (reqReady) begin
          nextState  = ST_WAIT;
          ctl.incPc  = !discard && !redirectValid;
        end
      end
      ST_WAIT: begin
        rspReady = dropRsp || slotFree;
        if (rspValid && rspReady) begin
          nextDiscard = 1'b0;
          if (dropRsp) begin
            nextState = ST_IDLE;
          end else begin
            ctl.writeInst = 1'b1;
            nextState     = rspErr ? ST_HALT : ST_IDLE;
          end
        end else if (redirectValid) begin
          nextDiscard = 1'b1;
        end
      end
      ST_HALT: begin
        if (redirectValid) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      discard <= 1'b0;
    end else begin
      state   <= nextState;
      discard <= nextDiscard;
    end
  end

  // R6: a handshake is followed by a cycle without a request
  assert_single_outstanding_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqValid);

  // R7: a dropped reply leaves the slot empty
  assert_stale_dropped_R7: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_WAIT && discard && rspValid && rspReady |=> !outValid);

endmodule

// File: rtl/ifetch_dpath.sv
module ifetch_dpath
  import ifetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  fetchCtl_t          ctl,
  input  logic [ADDR_W-1:0]  redirectPc,
  input  logic [DATA_W-1:0]  rspRdata,
  input  logic               rspErr,
  output logic               misaligned,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic               outValid,
  output logic [DATA_W-1:0]  outWord,
  output logic [ADDR_W-1:0]  outPc,
  output logic               outFault,
  output logic [CAUSE_W-1:0] outCause
);

  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(DATA_W / 8);

  logic [ADDR_W-1:0] fetchPc;
  logic [ADDR_W-1:0] addrReg;

  assign misaligned = fetchPc[1:0] != 2'b00;
  assign reqAddr    = addrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchPc <= RESET_PC;
      addrReg <= RESET_PC;
    end else begin
      if (ctl.redirect)   fetchPc <= redirectPc;
      else if (ctl.incPc) fetchPc <= addrReg + WORD_STEP;
      if (ctl.latchAddr)  addrReg <= fetchPc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outWord  <= '0;
      outPc    <= '0;
      outFault <= 1'b0;
      outCause <= '0;
    end else if (ctl.redirect) begin
      outValid <= 1'b0;
    end else if (ctl.writeInst) begin
      outValid <= 1'b1;
      outWord  <= rspRdata;
      outPc    <= addrReg;
      outFault <= rspErr;
      outCause <= rspErr ? CAUSE_ACCESS : '0;
    end else if (ctl.writeMisalign) begin
      outValid <= 1'b1;
      outWord  <= '0;
      outPc    <= fetchPc;
      outFault <= 1'b1;
      outCause <= CAUSE_MISALIGN;
    end else if (ctl.retire) begin
      outValid <= 1'b0;
    end
  end

  // R3: local fault only for an unaligned fetch address, with cause 0
  assert_misalign_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.writeMisalign |=> outValid && outFault && outCause == CAUSE_MISALIGN);

  // R4: bus error becomes cause 1
  assert_access_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.writeInst && rspErr |=> outValid && outFault && outCause == CAUSE_ACCESS);

  // R8: a stalled slot holds its contents
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !ctl.retire && !ctl.redirect |=>
      outValid && $stable(outWord) && $stable(outPc));

endmodule

// File: rtl/ifetch_master.sv
module ifetch_master
  import ifetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int AMO_W  = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                redirectValid,
  input  logic [ADDR_W-1:0]   redirectPc,
  input  logic                stall,
  output logic                reqValid,
  input  logic                reqReady,
  output logic [ADDR_W-1:0]   reqAddr,
  output logic                reqWe,
  output logic [1:0]          reqSize,
  output logic [DATA_W-1:0]   reqWdata,
  output logic [DATA_W/8-1:0] reqWstrb,
  output logic [AMO_W-1:0]    reqAmo,
  input  logic                rspValid,
  output logic                rspReady,
  input  logic [DATA_W-1:0]   rspRdata,
  input  logic                rspErr,
  output logic                instValid,
  output logic [DATA_W-1:0]   instWord,
  output logic [ADDR_W-1:0]   instPc,
  output logic                instFault,
  output logic [CAUSE_W-1:0]  instCause
);

  fetchCtl_t ctl;
  logic      misaligned;

  // read-only word fetch payload
  assign reqWe    = 1'b0;
  assign reqSize  = SIZE_WORD;
  assign reqWdata = '0;
  assign reqWstrb = '0;
  assign reqAmo   = '0;

  ifetch_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .redirectValid (redirectValid),
    .stall         (stall),
    .misaligned    (misaligned),
    .outValid      (instValid),
    .reqReady      (reqReady),
    .rspValid      (rspValid),
    .rspErr        (rspErr),
    .reqValid      (reqValid),
    .rspReady      (rspReady),
    .ctl           (ctl)
  );

  ifetch_dpath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RESET_PC (RESET_PC)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .redirectPc (redirectPc),
    .rspRdata   (rspRdata),
    .rspErr     (rspErr),
    .misaligned (misaligned),
    .reqAddr    (reqAddr),
    .outValid   (instValid),
    .outWord    (instWord),
    .outPc      (instPc),
    .outFault   (instFault),
    .outCause   (instCause)
  );

  // R2: a pending request keeps its address
  assert_req_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr));

  // R3: the bus never sees an unaligned fetch
  assert_req_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqAddr[1:0] == 2'b00);

endmodule

// File: tb/test_ifetch_master.sv
`timescale 1ns/1ps
module test_ifetch_master;

  localparam int          CYCLES = 3000;
  localparam logic [31:0] RST_PC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        redirectValid = 1'b0;
  logic [31:0] redirectPc = '0;
  logic        stall = 1'b0;
  logic        reqValid, reqReady = 1'b0;
  logic [31:0] reqAddr;
  logic        reqWe;
  logic [1:0]  reqSize;
  logic [31:0] reqWdata;
  logic [3:0]  reqWstrb;
  logic [3:0]  reqAmo;
  logic        rspValid = 1'b0, rspReady;
  logic [31:0] rspRdata = '0;
  logic        rspErr = 1'b0;
  logic        instValid;
  logic [31:0] instWord, instPc;
  logic        instFault;
  logic [3:0]  instCause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ifetch_master #(.RESET_PC(RST_PC)) i_ifetch_master (
    .clk(clk), .rstN(rstN), .redirectValid(redirectValid), .redirectPc(redirectPc),
    .stall(stall), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqWe(reqWe), .reqSize(reqSize), .reqWdata(reqWdata), .reqWstrb(reqWstrb),
    .reqAmo(reqAmo), .rspValid(rspValid), .rspReady(rspReady), .rspRdata(rspRdata),
    .rspErr(rspErr), .instValid(instValid), .instWord(instWord), .instPc(instPc),
    .instFault(instFault), .instCause(instCause)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[31:16] + a[15:0] + 16'h1234};
  endfunction

  function automatic bit errAddr(input logic [31:0] a);
    return a[11:8] == 4'hF;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // bench model state
    logic [31:0] expPc, expReqAddr, heldWord, heldPc, prevAddr, pendAddr, target;
    bit pending, stale, halted, heldPrev, redirPrev, showPrev, prevWaitReq;
    bit stallV, redirV, readyV, hsReq, hsRsp, respStale, staleReq;
    int lat, consumed, stallPct, readyPct, redirPct, latMax;
    int unsigned seedDummy;
    seedDummy = $urandom(32'd20260);
    expPc = RST_PC; expReqAddr = RST_PC; heldWord = '0; heldPc = '0;
    prevAddr = '0; pendAddr = '0; target = '0;
    pending = 0; stale = 0; halted = 0; heldPrev = 0; redirPrev = 0;
    showPrev = 0; prevWaitReq = 0; lat = 0; consumed = 0;

    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      chk(reqValid == 1'b0, "R9 reqValid in reset", 32'(reqValid), 32'd0);
      chk(instValid == 1'b0, "R9 instValid in reset", 32'(instValid), 32'd0);
    end
    rstN = 1'b1;

    for (int i = 0; i < CYCLES; i++) begin
      @(negedge clk);
      // outputs now reflect the last rising edge
      if (heldPrev) begin
        chk(instValid == 1'b1, "R8 valid held", 32'(instValid), 32'd1);
        chk(instWord == heldWord && instPc == heldPc, "R8 slot held", instPc, heldPc);
      end
      if (redirPrev)
        chk(instValid == 1'b0, "R7 slot cleared by redirect", 32'(instValid), 32'd0);
      if (showPrev)
        chk(instValid == 1'b1, "R5 R10 shown after response", 32'(instValid), 32'd1);

      // knobs per phase
      if (i < 30) begin
        stallPct = 0; readyPct = 100; redirPct = 0; latMax = 0;
      end else if (i < 1500) begin
        stallPct = 30; readyPct = 60; redirPct = 3; latMax = 3;
      end else begin
        stallPct = 50; readyPct = 30; redirPct = 8; latMax = 6;
      end
      stallV = ($urandom % 100) < stallPct;
      readyV = ($urandom % 100) < readyPct;
      redirV = ($urandom % 100) < (halted ? 25 : redirPct);
      target = $urandom & 32'h0000_3FFC;
      if (($urandom % 16) == 0) target[1:0] = 2'(1 + ($urandom % 3));
      // directed corners
      if (i == 40)  begin redirV = 1; target = 32'h0000_0F02; end
      if (i == 90)  begin redirV = 1; target = 32'h0000_2EF8; end
      if (i == 31 || i == 41 || i == 89) redirV = 0;
      if (i >= 300 && i <= 306) begin
        readyV = 0; redirV = (i == 302); target = 32'h0000_1230;
      end

      // slave response channel
      rspValid = 1'b0;
      if (pending) begin
        if (lat == 0) begin
          rspValid = 1'b1;
          rspRdata = memWord(pendAddr);
          rspErr   = errAddr(pendAddr);
        end else begin
          lat--;
        end
      end
      stall = stallV; reqReady = readyV;
      redirectValid = redirV; redirectPc = target;

      // consumption of the presented entry
      if (instValid && !stallV && !redirV) begin
        consumed++;
        chk(instPc == expPc, "R5 R7 instruction address", instPc, expPc);
        if (expPc[1:0] != 2'b00) begin
          chk(instFault && instCause == 4'd0, "R3 misaligned cause", 32'(instCause), 32'd0);
        end else if (errAddr(expPc)) begin
          chk(instFault && instCause == 4'd1, "R4 access fault cause", 32'(instCause), 32'd1);
        end else begin
          chk(!instFault && instCause == 4'd0, "R5 no fault", 32'(instFault), 32'd0);
          chk(instWord == memWord(expPc), "R5 instruction word", instWord, memWord(expPc));
        end
        if (instFault) halted = 1; else expPc += 4;
      end
      heldPrev = instValid && stallV && !redirV;
      heldWord = instWord; heldPc = instPc;

      #1;
      hsReq = reqValid && reqReady;
      hsRsp = rspValid && rspReady;
      if (reqValid) begin
        chk(reqWe == 1'b0 && reqAmo == 4'd0, "R1 write and atomic fields", {reqAmo, 3'b0, reqWe}, 32'd0);
        chk(reqSize == 2'b10, "R1 size word", 32'(reqSize), 32'd2);
        chk(reqWstrb == 4'd0 && reqWdata == 32'd0, "R1 strobes and data", reqWdata | 32'(reqWstrb), 32'd0);
        chk(reqAddr[1:0] == 2'b00, "R3 aligned request", reqAddr, reqAddr & 32'hFFFF_FFFC);
        chk(!halted, "R3 R4 no fetch after fault", 32'(halted), 32'd0);
        chk(!pending, "R6 one outstanding", 32'(pending), 32'd0);
      end
      if (prevWaitReq)
        chk(reqValid && reqAddr == prevAddr, "R2 request held", reqAddr, prevAddr);
      if (pending && rspValid && instValid && stallV && !redirV && !stale)
        chk(rspReady == 1'b0, "R8 response backpressure", 32'(rspReady), 32'd0);

      // model update
      respStale = 0;
      if (hsRsp) begin
        respStale = stale || redirV;
        pending = 0; stale = 0;
      end
      showPrev = hsRsp && !respStale;
      staleReq = stale || redirV;
      if (hsReq) begin
        if (!staleReq) begin
          chk(reqAddr == expReqAddr, "R7 R9 fresh request address", reqAddr, expReqAddr);
          expReqAddr += 4;
        end
        pending = 1; pendAddr = reqAddr;
        lat = (latMax == 0) ? 0 : int'($urandom % (latMax + 1));
        if (staleReq) stale = 1;
      end
      if (redirV) begin
        if (reqValid || pending) stale = 1;
        expReqAddr = target; expPc = target; halted = 0;
      end
      redirPrev = redirV;
      prevWaitReq = reqValid && !reqReady;
      prevAddr = reqAddr;
    end

    chk(consumed > 100, "R5 R10 progress", 32'(consumed), 32'd100);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule